// File: doc/BRIEF.md
# Internet Checksum Engine

This block produces the 16-bit ones'-complement checksum used by IPv4 headers and by ICMP and UDP segments. The caller streams the covered bytes in one per cycle, marking the opening byte and the closing byte, and may flag any byte as one that must count as zero. That flag lets the checksum field of a received packet stay in the stream while it is excluded from the sum. Bytes are paired into big-endian words and the words are added into a wide accumulator. At the end the carries are folded back into 16 bits and the folded sum is inverted.

A second operation builds the checksum of an echo reply from the checksum of the echo request, without reading the packet again. The caller presents the request checksum in one cycle. The engine inverts it, subtracts the type-field change of 0x0800 in ones'-complement arithmetic, and inverts the result. This operation does not disturb a stream that is already in progress. The caller assembles the UDP pseudo-header before it reaches this block.

Top module: `ck_engine`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `csum_done` is 0 and `csum_out` is 0x0000.
- R2: Stream bytes are paired in arrival order into 16-bit words, with the first byte of each pair in bits 15:8. The words are summed and the result is the bitwise NOT of the folded sum. For example, the 20-byte IPv4 header 45 00 00 73 00 00 40 00 40 11 xx xx C0 A8 00 01 C0 A8 00 C7 yields 0xB861 when the two xx bytes are zeroed.
- R3: Carries above bit 15 are folded back repeatedly until none remain. The stream FF FF FF FF 00 01 yields 0xFFFE.
- R4: A byte accepted with `in_zero`=1 contributes 0x00, whatever its value.
- R5: An odd-length stream has its final byte placed in bits 15:8 of a word whose bits 7:0 are zero. The stream 01 02 03 yields 0xFBFD.
- R6: `csum_done` is high for exactly the one cycle after the cycle that accepts a byte with `in_last`=1. `csum_out` holds that result until the next done pulse.
- R7: A byte accepted with `in_first`=1 discards all earlier partial sums and any unpaired byte.
- R8: Cycles with `in_valid`=0 change neither the sum nor the outputs.
- R9: A cycle with `in_valid`=1 and `upd_mode`=1 is an echo-reply update. One cycle later `csum_done` pulses and `csum_out` = NOT((NOT `prior_csum`) + 0xF7FF), where the sum is taken with end-around carry. For example, 0x1234 gives 0x1A34, 0xFC00 gives 0x0401, 0xFFFF gives 0x0800 and 0xF7FF gives 0x0000.
- R10: An update cycle leaves the stream state (partial sum and unpaired byte) untouched, so a stream split around it still produces its correct checksum.
- R11: A single-byte stream, with `in_first` and `in_last` set on the same byte, yields NOT({byte, 0x00}).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies a byte or an update request this cycle |
| in_first | input | 1 | This byte opens a new stream |
| in_last | input | 1 | This byte closes the stream |
| in_data | input | 8 | Stream byte |
| in_zero | input | 1 | Count this byte as 0x00 |
| upd_mode | input | 1 | 1 = echo-reply update, 0 = stream byte |
| prior_csum | input | 16 | Request checksum for the update operation |
| csum_out | output | 16 | Registered checksum result |
| csum_done | output | 1 | One-cycle pulse when `csum_out` is new |

## Verification
The stream path is driven with a real IPv4 header whose checksum bytes hold a nonzero value under the zero mask. This case distinguishes correct word pairing and masking from byte-swapped or unmasked sums. A run of 0xFF bytes exposes a single fold where a repeated fold is needed, and odd-length and one-byte streams show whether the pad byte lands in the low half. Streams interrupted by idle cycles, by a fresh start marker or by an echo-reply update check that the partial state is kept or discarded exactly as required. A table of request checksums, including the two zero encodings and values that borrow across bit 15, checks the update arithmetic.

// File: rtl/ck_pkg.sv
package ck_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ck_fold.sv
module ck_fold
  import ck_pkg::*;
#(
  parameter int IN_W = 32
) (
  input  logic [IN_W-1:0] sum_in,
  output word_t           fold_out
);
  localparam int STAGES = (IN_W + WORD_W - 1) / WORD_W;

  logic [IN_W-1:0] st [STAGES+1];
  assign st[0] = sum_in;

  for (genvar k = 0; k < STAGES; k++) begin : g_fold
    assign st[k+1] = IN_W'(st[k][WORD_W-1:0]) + (st[k] >> WORD_W);
  end

  assign fold_out = st[STAGES][WORD_W-1:0];
endmodule

// File: rtl/ck_word_pack.sv
module ck_word_pack
  import ck_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  take,
  input  logic  first,
  input  logic  last,
  input  byte_t data,
  input  logic  zero,
  output logic  word_vld,
  output word_t word
);
  byte_t hi_q;
  logic  have_q;
  logic  have_eff;
  byte_t b;

  assign b        = zero ? '0 : data;
  assign have_eff = have_q & ~first;

  always_comb begin
    word_vld = 1'b0;
    word     = '0;
    if (take) begin
      if (have_eff) begin
        word_vld = 1'b1;
        word     = {hi_q, b};
      end else if (last) begin
        word_vld = 1'b1;
        word     = {b, {BYTE_W{1'b0}}};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      have_q <= 1'b0;
    end else if (take) begin
      if (!have_eff && !last) begin
        hi_q   <= b;
        have_q <= 1'b1;
      end else begin
        have_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ck_accum.sv
module ck_accum
  import ck_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             first,
  input  logic             last,
  input  logic             word_vld,
  input  word_t            word,
  output logic [ACC_W-1:0] sum_next
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] base;

  assign base     = first ? '0 : acc_q;
  assign sum_next = word_vld ? base + ACC_W'(word) : base;

  always_ff @(posedge clk) begin
    if (rst)
      acc_q <= '0;
    else if (take)
      acc_q <= last ? '0 : sum_next;
  end
endmodule

// File: rtl/ck_reply.sv
module ck_reply
  import ck_pkg::*;
#(
  parameter logic [15:0] DELTA = 16'h0800
) (
  input  word_t prior,
  output word_t reply
);
  localparam int SUM_W = WORD_W + 1;

  logic [SUM_W-1:0] raw;
  word_t            folded;

  assign raw = SUM_W'(~prior) + SUM_W'(~DELTA);

  ck_fold #(.IN_W(SUM_W)) u_fold (
    .sum_in   (raw),
    .fold_out (folded)
  );

  assign reply = ~folded;
endmodule

// File: rtl/ck_engine.sv
module ck_engine
  import ck_pkg::*;
#(
  parameter int          ACC_W = 32,
  parameter logic [15:0] DELTA = 16'h0800
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic        in_first,
  input  logic        in_last,
  input  logic [7:0]  in_data,
  input  logic        in_zero,
  input  logic        upd_mode,
  input  logic [15:0] prior_csum,
  output logic [15:0] csum_out,
  output logic        csum_done
);
  logic             stream_go;
  logic             upd_go;
  logic             word_vld;
  word_t            word;
  logic [ACC_W-1:0] sum_next;
  word_t            folded;
  word_t            reply;

  assign stream_go = in_valid & ~upd_mode;
  assign upd_go    = in_valid & upd_mode;

  ck_word_pack u_pack (
    .clk      (clk),
    .rst      (rst),
    .take     (stream_go),
    .first    (in_first),
    .last     (in_last),
    .data     (in_data),
    .zero     (in_zero),
    .word_vld (word_vld),
    .word     (word)
  );

  ck_accum #(.ACC_W(ACC_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .take     (stream_go),
    .first    (in_first),
    .last     (in_last),
    .word_vld (word_vld),
    .word     (word),
    .sum_next (sum_next)
  );

  ck_fold #(.IN_W(ACC_W)) u_fold (
    .sum_in   (sum_next),
    .fold_out (folded)
  );

  ck_reply #(.DELTA(DELTA)) u_reply (
    .prior (prior_csum),
    .reply (reply)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      csum_out  <= '0;
      csum_done <= 1'b0;
    end else begin
      csum_done <= upd_go | (stream_go & in_last);
      if (upd_go)
        csum_out <= reply;
      else if (stream_go && in_last)
        csum_out <= ~folded;
    end
  end
endmodule

// File: rtl/ck_engine_chk.sv
module ck_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_last,
  input logic        upd_mode,
  input logic [15:0] prior_csum,
  input logic [15:0] csum_out,
  input logic        csum_done
);
  function automatic logic [15:0] plus_delta(input logic [15:0] p);
    logic [16:0] s;
    s = {1'b0, p} + 17'h00800;
    return s[15:0] + {15'd0, s[16]};
  endfunction

  // R1
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!csum_done && csum_out == 16'h0000));

  // R6
  p_done_after_last_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_last || upd_mode)) |=> csum_done);

  // R8
  p_no_stray_done_r8: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && (in_last || upd_mode)) |=> !csum_done);

  // R6
  p_result_held_r6: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && (in_last || upd_mode)) |=> $stable(csum_out));

  // R9
  p_reply_value_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && upd_mode && prior_csum != 16'hF7FF)
      |=> csum_out == plus_delta($past(prior_csum)));
endmodule

bind ck_engine ck_engine_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_last    (in_last),
  .upd_mode   (upd_mode),
  .prior_csum (prior_csum),
  .csum_out   (csum_out),
  .csum_done  (csum_done)
);

// File: tb/ck_engine_tb.sv
module ck_engine_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, in_zero = 1'b0;
  logic        upd_mode = 1'b0;
  logic [7:0]  in_data = '0;
  logic [15:0] prior_csum = '0;
  logic [15:0] csum_out;
  logic        csum_done;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] sb [64];
  logic       sm [64];

  // {prior, expected reply}
  localparam logic [31:0] INC_VEC [6] = '{
    {16'h1234, 16'h1A34},
    {16'hFC00, 16'h0401},
    {16'hFFFF, 16'h0800},
    {16'h0000, 16'h0800},
    {16'hF7FF, 16'h0000},
    {16'hB861, 16'hC061}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  ck_engine u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_data(in_data), .in_zero(in_zero),
    .upd_mode(upd_mode), .prior_csum(prior_csum),
    .csum_out(csum_out), .csum_done(csum_done)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] model(input int n);
    logic [31:0] s = 0;
    for (int i = 0; i < n; i += 2) begin
      logic [7:0] h = sm[i] ? 8'h00 : sb[i];
      logic [7:0] l = (i + 1 < n && !sm[i+1]) ? sb[i+1] : 8'h00;
      s += {16'd0, h, l};
    end
    while (s[31:16] != 0) s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
    return ~s[15:0];
  endfunction

  task automatic put(input int i, input logic f, input logic l);
    @(negedge clk);
    in_valid = 1'b1; upd_mode = 1'b0; in_first = f; in_last = l;
    in_data = sb[i]; in_zero = sm[i];
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; upd_mode = 1'b0;
  endtask

  // drive bytes [lo,hi); check after the final byte when fin is set
  task automatic span(input string req, input int lo, input int hi,
                      input logic f, input logic fin, input int gap_at);
    for (int i = lo; i < hi; i++) begin
      if (i == gap_at) begin idle(); idle(); end
      put(i, f && i == lo, fin && i == hi - 1);
    end
    if (fin) begin
      idle();
      check({req, " done"}, csum_done, 1);
      check({req, " value"}, csum_out, model(hi));
      @(negedge clk);
      check({req, " pulse width R6"}, csum_done, 0);
      check({req, " held R6"}, csum_out, model(hi));
    end
  endtask

  task automatic reply(input logic [15:0] p, input logic [15:0] e);
    @(negedge clk);
    in_valid = 1'b1; upd_mode = 1'b1; prior_csum = p;
    in_first = 1'b0; in_last = 1'b0;
    idle();
    check("R9 reply done", csum_done, 1);
    check("R9 reply value", csum_out, e);
  endtask

  task automatic clear_buf();
    for (int i = 0; i < 64; i++) begin sb[i] = 8'h00; sm[i] = 1'b0; end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear_buf();
    repeat (3) @(negedge clk);
    check("R1 done in reset", csum_done, 0);
    check("R1 value in reset", csum_out, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done after reset", csum_done, 0);
    check("R1 value after reset", csum_out, 0);

    // R9 table walk
    for (int v = 0; v < 6; v++) reply(INC_VEC[v][31:16], INC_VEC[v][15:0]);

    // R2 R4: IPv4 header with checksum bytes masked
    begin
      logic [7:0] hdr [20] = '{8'h45,8'h00,8'h00,8'h73,8'h00,8'h00,8'h40,8'h00,
                               8'h40,8'h11,8'hB8,8'h61,8'hC0,8'hA8,8'h00,8'h01,
                               8'hC0,8'hA8,8'h00,8'hC7};
      clear_buf();
      for (int i = 0; i < 20; i++) sb[i] = hdr[i];
      sm[10] = 1'b1; sm[11] = 1'b1;
      span("R2 R4 ip header", 0, 20, 1'b1, 1'b1, -1);
      check("R2 known header value", csum_out, 16'hB861);
    end

    // R3 repeated fold
    clear_buf();
    sb[0]=8'hFF; sb[1]=8'hFF; sb[2]=8'hFF; sb[3]=8'hFF; sb[4]=8'h00; sb[5]=8'h01;
    span("R3 fold", 0, 6, 1'b1, 1'b1, -1);
    check("R3 fold literal", csum_out, 16'hFFFE);

    // R5 odd length
    clear_buf();
    sb[0]=8'h01; sb[1]=8'h02; sb[2]=8'h03;
    span("R5 odd", 0, 3, 1'b1, 1'b1, -1);
    check("R5 odd literal", csum_out, 16'hFBFD);

    // R11 single byte
    clear_buf();
    sb[0]=8'hAB;
    span("R11 single", 0, 1, 1'b1, 1'b1, -1);
    check("R11 single literal", csum_out, 16'h54FF);

    // R8 idle gaps inside an odd pairing
    clear_buf();
    for (int i = 0; i < 9; i++) sb[i] = 8'(8'h31 * (i + 1));
    span("R8 gaps", 0, 9, 1'b1, 1'b1, 3);

    // R7 restart discards partial sum and unpaired byte
    clear_buf();
    sb[0]=8'hFF; sb[1]=8'hFF; sb[2]=8'h12;
    span("R7 partial", 0, 3, 1'b1, 1'b0, -1);
    idle();
    check("R7 no done on partial", csum_done, 0);
    sb[0]=8'hAB; sb[1]=8'hCD;
    span("R7 restart", 0, 2, 1'b1, 1'b1, -1);
    check("R7 restart literal", csum_out, 16'h5432);

    // R10 update in the middle of a stream (after an odd byte count)
    clear_buf();
    for (int i = 0; i < 8; i++) sb[i] = 8'(8'hA5 ^ (8'(i) << 3));
    span("R10 head", 0, 3, 1'b1, 1'b0, -1);
    reply(16'h1234, 16'h1A34);
    span("R10 tail", 3, 8, 1'b0, 1'b1, -1);

    idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule